// File: doc/BRIEF.md
# Receive Acquisition Detector with Delimiter Search Window

This block controls the early part of a receive burst. At the end of each antenna dwell, the demodulator presents two measurements together with a dwell-done strobe. One is the amplitude quality of the bit-synchroniser and the other is the variance of the carrier phase. The block compares both against thresholds that software programs. It declares acquisition only when the amplitude is above its limit and the variance is below its limit. Each threshold is wider than one byte, so software loads it as a separate high byte and low byte.

After acquisition the block waits for a start-frame delimiter. It counts symbol strobes against a programmable window. If the window runs out before a delimiter-found pulse arrives, the block emits a one-cycle timeout and returns to acquisition. If the delimiter arrives in time, the block moves to a header state and stays there until the end of the burst. A separate energy-detect flag compares the 6-bit received-signal-strength value with a 6-bit threshold. The all-ones threshold value turns that flag off.

The controller has three states: ACQUIRE, SFD_SEARCH and HEADER. It has four transitions:
- ACQUIRE to SFD_SEARCH when a dwell passes both tests (acquire).
- SFD_SEARCH to HEADER on a delimiter-found pulse (delimiter).
- SFD_SEARCH to ACQUIRE when the window expires (timeout).
- HEADER to ACQUIRE on the end-of-burst pulse (burst end).

Top module: `acq_sfd_ctrl`

## Requirements
- R1: After reset the state is ACQUIRE, and `acq_pulse`, `ed_flag` and `sfd_timeout` are 0. The configuration registers read back 00h, except the energy threshold, which reads 3Fh.
- R2: The amplitude threshold is 15 bits wide. A write to address 0 loads bits 14:8 from data bits 6:0, and data bit 7 is discarded, so address 0 reads back with bit 7 at 0. A write to address 1 loads bits 7:0.
- R3: The variance threshold is 16 bits wide. Address 2 holds bits 15:8 and address 3 holds bits 7:0, and both read back unchanged.
- R4: In ACQUIRE, suppose a `dwell_done` cycle has `amp_meas` strictly greater than the amplitude threshold and `var_meas` strictly less than the variance threshold. Then `acq_pulse` is 1 for exactly one cycle starting at the next clock edge, and the state becomes SFD_SEARCH at that same edge.
- R5: If a measurement equals its threshold, or if either test fails, the dwell gives no `acq_pulse` and the state stays ACQUIRE.
- R6: A `dwell_done` strobe in SFD_SEARCH or HEADER has no effect.
- R7: `ed_flag` is registered. It goes to 1 one cycle after `rssi` exceeds the energy threshold bits 5:0. An energy threshold of 3Fh holds `ed_flag` at 0. Energy threshold bits 7:6 (address 4) read back as written but change nothing.
- R8: The search window is loaded on entry to SFD_SEARCH from the register at address 5 (N). Every `sym_tick` in SFD_SEARCH counts down. On the N-th tick, or on the first tick when N is 0, `sfd_timeout` pulses for one cycle and the state returns to ACQUIRE.
- R9: A `sfd_found` pulse in SFD_SEARCH moves the state to HEADER. The delimiter wins over a window expiry in the same cycle, and in that case no timeout is raised.
- R10: HEADER returns to ACQUIRE on `rx_end`. Outside their own states, `sfd_found`, `sym_tick` and `rx_end` have no effect.
- R11: `state` encodes ACQUIRE as 0, SFD_SEARCH as 1 and HEADER as 2. Addresses 6 and 7 read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address for write and readback |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the addressed register |
| dwell_done | input | 1 | Marks the end of an antenna dwell, measurements valid |
| amp_meas | input | 15 | Bit-sync amplitude quality measurement |
| var_meas | input | 16 | Carrier phase variance measurement |
| rssi | input | 6 | Received signal strength |
| sym_tick | input | 1 | One pulse per symbol period |
| sfd_found | input | 1 | Delimiter detected |
| rx_end | input | 1 | End of burst, leaves HEADER |
| acq_pulse | output | 1 | One-cycle acquisition indication |
| ed_flag | output | 1 | Energy detect |
| sfd_timeout | output | 1 | One-cycle search window expiry |
| state | output | 2 | Controller state |

## Verification
The assertions assume every input changes only between clock edges and that strobes last a single cycle. They also assume register writes and measurements can arrive in any state, including in the same cycle as a dwell. The bench drives every input on the falling edge. A behavioural model predicts each output and compares on every rising edge, both during directed boundary cases and during a long random stretch. In that stretch, writes and the three strobes are interleaved freely, including the delimiter and the expiring tick in the same cycle.

// File: rtl/acq_sfd_pkg.sv
package acq_sfd_pkg;

    localparam int CFG_AW = 3;
    localparam int CFG_DW = 8;

    typedef enum logic [1:0] {
        ST_ACQUIRE    = 2'd0,
        ST_SFD_SEARCH = 2'd1,
        ST_HEADER     = 2'd2
    } rx_state_e;

    localparam logic [CFG_AW-1:0] A_AMP_HI = 3'd0;
    localparam logic [CFG_AW-1:0] A_AMP_LO = 3'd1;
    localparam logic [CFG_AW-1:0] A_VAR_HI = 3'd2;
    localparam logic [CFG_AW-1:0] A_VAR_LO = 3'd3;
    localparam logic [CFG_AW-1:0] A_ED_THR = 3'd4;
    localparam logic [CFG_AW-1:0] A_SFD_LEN = 3'd5;

endpackage

// File: rtl/acq_sfd_regs.sv
module acq_sfd_regs
    import acq_sfd_pkg::*;
#(
    parameter int AMP_W  = 15,
    parameter int VAR_W  = 16,
    parameter int RSSI_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CFG_AW-1:0]   addr,
    input  logic [CFG_DW-1:0]   wdata,
    output logic [CFG_DW-1:0]   rdata,
    output logic [AMP_W-1:0]    amp_thr,
    output logic [VAR_W-1:0]    var_thr,
    output logic [RSSI_W-1:0]   ed_thr,
    output logic [CNT_W-1:0]    sfd_len
);
    localparam int AMP_HI_W = AMP_W - CFG_DW;
    localparam int VAR_HI_W = VAR_W - CFG_DW;

    logic [AMP_HI_W-1:0] amp_hi_q;
    logic [CFG_DW-1:0]   amp_lo_q;
    logic [VAR_HI_W-1:0] var_hi_q;
    logic [CFG_DW-1:0]   var_lo_q;
    logic [CFG_DW-1:0]   ed_q;
    logic [CNT_W-1:0]    len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amp_hi_q <= '0;
            amp_lo_q <= '0;
            var_hi_q <= '0;
            var_lo_q <= '0;
            ed_q     <= CFG_DW'({RSSI_W{1'b1}});
            len_q    <= '0;
        end else if (we) begin
            unique case (addr)
                A_AMP_HI:  amp_hi_q <= wdata[AMP_HI_W-1:0];
                A_AMP_LO:  amp_lo_q <= wdata;
                A_VAR_HI:  var_hi_q <= wdata[VAR_HI_W-1:0];
                A_VAR_LO:  var_lo_q <= wdata;
                A_ED_THR:  ed_q     <= wdata;
                A_SFD_LEN: len_q    <= wdata[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_AMP_HI:  rdata = CFG_DW'(amp_hi_q);
            A_AMP_LO:  rdata = amp_lo_q;
            A_VAR_HI:  rdata = CFG_DW'(var_hi_q);
            A_VAR_LO:  rdata = var_lo_q;
            A_ED_THR:  rdata = ed_q;
            A_SFD_LEN: rdata = CFG_DW'(len_q);
            default:   rdata = '0;
        endcase
    end

    assign amp_thr = {amp_hi_q, amp_lo_q};
    assign var_thr = {var_hi_q, var_lo_q};
    assign ed_thr  = ed_q[RSSI_W-1:0];
    assign sfd_len = len_q;

    // R11
    unused_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > A_SFD_LEN) |=> ($stable(amp_thr) && $stable(var_thr) && $stable(ed_q) && $stable(len_q)));

endmodule

// File: rtl/acq_qual_cmp.sv
module acq_qual_cmp #(
    parameter int AMP_W  = 15,
    parameter int VAR_W  = 16,
    parameter int RSSI_W = 6
) (
    input  logic [AMP_W-1:0]  amp_meas,
    input  logic [AMP_W-1:0]  amp_thr,
    input  logic [VAR_W-1:0]  var_meas,
    input  logic [VAR_W-1:0]  var_thr,
    input  logic [RSSI_W-1:0] rssi,
    input  logic [RSSI_W-1:0] ed_thr,
    output logic              dwell_ok,
    output logic              energy_hit
);
    localparam logic [RSSI_W-1:0] ED_OFF = {RSSI_W{1'b1}};

    logic amp_ok;
    logic var_ok;

    always_comb begin
        amp_ok     = amp_meas > amp_thr;
        var_ok     = var_meas < var_thr;
        dwell_ok   = amp_ok && var_ok;
        energy_hit = (ed_thr != ED_OFF) && (rssi > ed_thr);
    end

endmodule

// File: rtl/sfd_window_ctr.sv
module sfd_window_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             active,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (active && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire = active && tick && (cnt_q <= ONE);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(active && tick)) |=> $stable(cnt_q));

endmodule

// File: rtl/acq_sfd_ctrl.sv
module acq_sfd_ctrl
    import acq_sfd_pkg::*;
#(
    parameter int AMP_W  = 15,
    parameter int VAR_W  = 16,
    parameter int RSSI_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              dwell_done,
    input  logic [AMP_W-1:0]  amp_meas,
    input  logic [VAR_W-1:0]  var_meas,
    input  logic [RSSI_W-1:0] rssi,
    input  logic              sym_tick,
    input  logic              sfd_found,
    input  logic              rx_end,
    output logic              acq_pulse,
    output logic              ed_flag,
    output logic              sfd_timeout,
    output logic [1:0]        state
);
    logic [AMP_W-1:0]  amp_thr;
    logic [VAR_W-1:0]  var_thr;
    logic [RSSI_W-1:0] ed_thr;
    logic [CNT_W-1:0]  sfd_len;
    logic              dwell_ok;
    logic              energy_hit;
    logic              win_expire;
    logic              searching;
    logic              take_acq;
    logic              take_timeout;

    rx_state_e state_q, state_d;

    acq_sfd_regs #(
        .AMP_W(AMP_W), .VAR_W(VAR_W), .RSSI_W(RSSI_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .amp_thr(amp_thr),
        .var_thr(var_thr), .ed_thr(ed_thr), .sfd_len(sfd_len)
    );

    acq_qual_cmp #(
        .AMP_W(AMP_W), .VAR_W(VAR_W), .RSSI_W(RSSI_W)
    ) u_cmp (
        .amp_meas(amp_meas), .amp_thr(amp_thr), .var_meas(var_meas),
        .var_thr(var_thr), .rssi(rssi), .ed_thr(ed_thr),
        .dwell_ok(dwell_ok), .energy_hit(energy_hit)
    );

    assign searching    = (state_q == ST_SFD_SEARCH);
    assign take_acq     = (state_q == ST_ACQUIRE) && dwell_done && dwell_ok;
    assign take_timeout = searching && !sfd_found && win_expire;

    sfd_window_ctr #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .load(take_acq), .load_val(sfd_len),
        .active(searching), .tick(sym_tick), .expire(win_expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE:    if (take_acq) state_d = ST_SFD_SEARCH;
            ST_SFD_SEARCH: begin
                if (sfd_found)         state_d = ST_HEADER;
                else if (win_expire)   state_d = ST_ACQUIRE;
            end
            ST_HEADER:     if (rx_end) state_d = ST_ACQUIRE;
            default:       state_d = ST_ACQUIRE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_pulse   <= 1'b0;
            sfd_timeout <= 1'b0;
            ed_flag     <= 1'b0;
        end else begin
            acq_pulse   <= take_acq;
            sfd_timeout <= take_timeout;
            ed_flag     <= energy_hit;
        end
    end

    assign state = state_q;

    // R4
    acq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_pulse |-> (state_q == ST_SFD_SEARCH && $past(state_q) == ST_ACQUIRE));

    // R4
    acq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_pulse |=> !acq_pulse);

    // R8
    timeout_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfd_timeout |-> (state_q == ST_ACQUIRE && $past(state_q) == ST_SFD_SEARCH));

    // R9
    sfd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (searching && sfd_found) |=> (state_q == ST_HEADER && !sfd_timeout));

    // R7
    ed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ed_thr == {RSSI_W{1'b1}}) |=> !ed_flag);

    // R10
    header_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER) |=> (state_q != ST_SFD_SEARCH));

    // R11
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);

    // R6
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acq_pulse, sfd_timeout}));

endmodule

// File: tb/acq_sfd_ctrl_bench.sv
`timescale 1ns/1ps
module acq_sfd_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        dwell_done = 1'b0;
    logic [14:0] amp_meas = '0;
    logic [15:0] var_meas = '0;
    logic [5:0]  rssi = '0;
    logic        sym_tick = 1'b0;
    logic        sfd_found = 1'b0;
    logic        rx_end = 1'b0;
    logic        acq_pulse, ed_flag, sfd_timeout;
    logic [1:0]  state;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    acq_sfd_ctrl u_acq_sfd_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dwell_done(dwell_done),
        .amp_meas(amp_meas), .var_meas(var_meas), .rssi(rssi),
        .sym_tick(sym_tick), .sfd_found(sfd_found), .rx_end(rx_end),
        .acq_pulse(acq_pulse), .ed_flag(ed_flag), .sfd_timeout(sfd_timeout),
        .state(state)
    );

    // behavioural reference model
    int m_reg [8];
    int m_state, m_cnt;
    bit m_acq, m_to, m_ed;

    task automatic model_reset();
        foreach (m_reg[i]) m_reg[i] = 0;
        m_reg[4] = 63;
        m_state = 0; m_cnt = 0; m_acq = 0; m_to = 0; m_ed = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int amp_t, var_t, ed_t, nstate;
            amp_t = m_reg[0] * 256 + m_reg[1];
            var_t = m_reg[2] * 256 + m_reg[3];
            ed_t  = m_reg[4] % 64;
            m_ed  = (ed_t != 63) && (int'(rssi) > ed_t);
            m_acq = 0; m_to = 0; nstate = m_state;
            if (m_state == 0) begin
                if (dwell_done && int'(amp_meas) > amp_t && int'(var_meas) < var_t) begin
                    m_acq = 1; nstate = 1; m_cnt = m_reg[5];
                end
            end else if (m_state == 1) begin
                if (sfd_found) nstate = 2;
                else if (sym_tick) begin
                    if (m_cnt <= 1) begin m_to = 1; nstate = 0; end
                    else m_cnt = m_cnt - 1;
                end
            end else begin
                if (rx_end) nstate = 0;
            end
            m_state = nstate;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_reg[0] = cfg_wdata % 128;
                    3'd1, 3'd2, 3'd3, 3'd4, 3'd5: m_reg[cfg_addr] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R4 acq_pulse", acq_pulse, m_acq);
            chk("R8 sfd_timeout", sfd_timeout, m_to);
            chk("R7 ed_flag", ed_flag, m_ed);
            chk("R11 state", state, m_state);
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 0; dwell_done = 0; sym_tick = 0; sfd_found = 0; rx_end = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); idle(); cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(negedge clk); idle();
    endtask

    task automatic rd(input string req, input int a, input int exp);
        @(negedge clk); idle(); cfg_addr = 3'(a); #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic dwell(input int a, input int v);
        @(negedge clk); idle(); dwell_done = 1; amp_meas = 15'(a); var_meas = 16'(v);
        @(negedge clk); idle();
    endtask

    task automatic pulse_tick(input bit found);
        @(negedge clk); idle(); sym_tick = 1; sfd_found = found;
        @(negedge clk); idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: outputs during and right after reset
        chk("R1 acq_pulse", acq_pulse, 0);
        chk("R1 state", state, 0);
        @(negedge clk); rst_n = 1;
        rd("R1 amp_hi", 0, 0);
        rd("R1 ed_thr", 4, 63);
        rd("R1 sfd_len", 5, 0);
        // R2: bit 7 of amp high byte dropped
        wr(0, 8'hFF); rd("R2 amp_hi", 0, 8'h7F);
        wr(0, 8'h01); wr(1, 8'h00);
        // R3
        wr(2, 8'h02); wr(3, 8'h00);
        rd("R3 var_hi", 2, 2); rd("R3 var_lo", 3, 0);
        wr(5, 3);
        // R11: unused address
        wr(6, 8'hAA); rd("R11 addr6", 6, 0);
        // R5: equality and single-test failures
        dwell(256, 100);
        dwell(257, 512);
        dwell(100, 10);
        cyc(1); chk("R5 state", state, 0);
        // R4: pass both
        dwell(257, 511);
        // R6: dwell ignored in search
        dwell(9000, 0);
        chk("R6 state", state, 1);
        // R8: window of three ticks
        pulse_tick(0); pulse_tick(0); cyc(2); pulse_tick(0);
        cyc(1); chk("R8 back", state, 0);
        // R9: delimiter wins against expiring tick
        wr(5, 1); dwell(300, 0);
        pulse_tick(1);
        cyc(1); chk("R9 header", state, 2);
        // R10: strobes ignored in header, rx_end leaves
        pulse_tick(1); dwell(300, 0);
        chk("R10 header", state, 2);
        @(negedge clk); idle(); rx_end = 1; @(negedge clk); idle();
        cyc(1); chk("R10 exit", state, 0);
        // R8: length 0 expires on first tick
        wr(5, 0); dwell(300, 0); pulse_tick(0);
        cyc(1); chk("R8 len0", state, 0);
        // R10: sfd_found in ACQUIRE ignored
        pulse_tick(1); chk("R10 acq", state, 0);
        // R7: energy detect
        wr(4, 8'hC5); rd("R7 ed_rb", 4, 8'hC5);
        @(negedge clk); rssi = 5; cyc(2); chk("R7 eq", ed_flag, 0);
        @(negedge clk); rssi = 6; cyc(2); chk("R7 above", ed_flag, 1);
        wr(4, 8'h3F); @(negedge clk); rssi = 63; cyc(2); chk("R7 off", ed_flag, 0);
        wr(4, 8'hFE); cyc(2); chk("R7 hi_bits", ed_flag, 1);
        // random stretch
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk); idle();
            if ($urandom_range(0, 15) == 0) begin
                cfg_we = 1; cfg_addr = 3'($urandom_range(0, 7));
                cfg_wdata = 8'($urandom_range(0, 255));
                if (cfg_addr == 3'd0) cfg_wdata = 8'($urandom_range(0, 3));
                if (cfg_addr == 3'd5) cfg_wdata = 8'($urandom_range(0, 6));
            end
            dwell_done = ($urandom_range(0, 5) == 0);
            amp_meas   = 15'($urandom_range(0, 1023));
            var_meas   = 16'($urandom_range(0, 1023));
            rssi       = 6'($urandom_range(0, 63));
            sym_tick   = ($urandom_range(0, 2) == 0);
            sfd_found  = ($urandom_range(0, 11) == 0);
            rx_end     = ($urandom_range(0, 9) == 0);
        end
        @(negedge clk); idle();
        cyc(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule